// File: doc/BRIEF.md
# Strobe/Acknowledge Channel Protocol Monitor

This block watches one point-to-point word channel without driving it. The channel has a data bus, a strobe raised by the sender when a word is valid, an acknowledge raised by the receiver when it can take a word, a shared clock and a synchronous active-high reset. A word moves at any rising edge where strobe and acknowledge are both high. Either side may hold its own line low to stall, and both lines may stay high across several edges so that words move on consecutive edges.

The monitor counts the words that move and keeps a copy of the most recent one. It reports the first rule violation it sees as a sticky 3-bit code. The code stays until a clear pulse or a reset. It also raises a sticky deadlock flag when a stall goes on for too long. A stall is either strobe high with no acknowledge, or both lines low while the sender reports that it has a word waiting. The bus width, the counter width and the stall limit are parameters.

Top module: `hs_chan_monitor`

## Requirements
- R1: A reset edge clears the transfer count, the captured word, the error code and the deadlock flag to zero.
- R2: At every edge with strobe and acknowledge both high, the count rises by one and the captured word takes the bus value. This also holds on consecutive edges with no idle cycle between them.
- R3: The transfer count saturates at all ones and does not wrap.
- R4: Code 1 (strobe dropped) is raised when strobe was high and acknowledge low at the previous edge, and strobe is low now.
- R5: Code 2 (acknowledge dropped) is raised when acknowledge was high and strobe low at the previous edge, and acknowledge is low now.
- R6: Code 3 (data unstable) is raised when strobe was high and acknowledge low at the previous edge, strobe is still high, and the bus value differs. Bus changes while strobe is low are ignored. A change at the edge right after a completed transfer is also ignored.
- R7: Code 4 (reset violation) is raised when strobe or acknowledge is high at the first edge after a reset edge.
- R8: Code 5 (stall timeout) and the deadlock flag are raised at the STALL_LIMIT-th consecutive edge with strobe high and acknowledge low. They are also raised at the STALL_LIMIT-th consecutive edge with both lines low and the pending input high. Both lines low with pending low never times out.
- R9: Only the first error is kept, and a later violation leaves the code unchanged. When several violations occur at one edge, the lowest code wins. An edge with the clear input high zeroes the code and the deadlock flag and ignores that edge's violations.
- R10: The first edge after reset has no history, so the hold rules in R4 to R6 do not use values sampled before or during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Pulse to clear the error code and the deadlock flag |
| ch_data | input | DATA_W | Observed data bus |
| ch_stb | input | 1 | Observed strobe (sender has a valid word) |
| ch_ack | input | 1 | Observed acknowledge (receiver ready) |
| tx_pending | input | 1 | Sender reports that a word is waiting |
| xfer_count | output | CNT_W | Saturating count of completed transfers |
| last_word | output | DATA_W | Bus value from the latest transfer |
| err_valid | output | 1 | High while the error code is non-zero |
| err_code | output | 3 | Sticky first error: 0 none, 1 strobe drop, 2 acknowledge drop, 3 data unstable, 4 reset violation, 5 stall timeout |
| deadlock | output | 1 | Sticky stall-timeout flag |

## Verification
Assertions check on every cycle that each hold-rule violation, seen from the port history, produces its code one edge later when no error is already held. They also check that a held code stays put, that the counter steps by one or stays at its maximum, and that a stall fires only after a run of stall edges. Only the bench scenarios show the wider behaviour. These include saturation at the all-ones count, the quiet treatment of bus changes while strobe is low or just after a transfer, the exemption of the first edge after reset, the exact edge at which each stall limit expires, and a clear pulse landing on an edge that would itself be a violation.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_STB_DROP = 3'd1,
    ERR_ACK_DROP = 3'd2,
    ERR_DATA     = 3'd3,
    ERR_RST      = 3'd4,
    ERR_STALL    = 3'd5
  } hs_err_e;

  localparam int STALL_KINDS = 2;

endpackage

// File: rtl/hs_mon_history.sv
module hs_mon_history #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              ack,
  input  logic [DATA_W-1:0] data,
  output logic              prev_stb,
  output logic              prev_ack,
  output logic [DATA_W-1:0] prev_data,
  output logic              hist_ok,
  output logic              after_rst
);

  // Line history is kept without reset; its validity bit is reset instead.
  always_ff @(posedge clk) begin
    prev_stb  <= stb;
    prev_ack  <= ack;
    prev_data <= data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_ok <= 1'b0;
    end else begin
      hist_ok <= 1'b1;
    end
    after_rst <= rst;
  end

  // R10
  hist_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    after_rst |-> !hist_ok);

endmodule

// File: rtl/hs_mon_stall.sv
module hs_mon_stall #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic fire
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_TOP = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1  = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      run_q <= '0;
    end else if (run_q != LIM_TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign fire = cond && (run_q == LIM_M1);

  // R8
  stall_run_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(cond));

endmodule

// File: rtl/hs_mon_stats.sv
module hs_mon_stats #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] word
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      word  <= '0;
    end else if (done) begin
      if (count != CNT_MAX) begin
        count <= count + 1'b1;
      end
      word <= data;
    end
  end

  // R3
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (done && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/hs_chan_monitor.sv
module hs_chan_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int STALL_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  logic [DATA_W-1:0] ch_data,
  input  logic              ch_stb,
  input  logic              ch_ack,
  input  logic              tx_pending,
  output logic [CNT_W-1:0]  xfer_count,
  output logic [DATA_W-1:0] last_word,
  output logic              err_valid,
  output logic [2:0]        err_code,
  output logic              deadlock
);

  logic              prev_stb;
  logic              prev_ack;
  logic [DATA_W-1:0] prev_data;
  logic              hist_ok;
  logic              after_rst;

  hs_mon_history #(.DATA_W(DATA_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .stb       (ch_stb),
    .ack       (ch_ack),
    .data      (ch_data),
    .prev_stb  (prev_stb),
    .prev_ack  (prev_ack),
    .prev_data (prev_data),
    .hist_ok   (hist_ok),
    .after_rst (after_rst)
  );

  hs_mon_stats #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stats (
    .clk   (clk),
    .rst   (rst),
    .done  (ch_stb && ch_ack),
    .data  (ch_data),
    .count (xfer_count),
    .word  (last_word)
  );

  // Stall watchers: 0 = strobe waiting on acknowledge, 1 = both idle with a word pending.
  logic [STALL_KINDS-1:0] stall_cond;
  logic [STALL_KINDS-1:0] stall_fire;

  assign stall_cond[0] = ch_stb && !ch_ack;
  assign stall_cond[1] = !ch_stb && !ch_ack && tx_pending;

  for (genvar k = 0; k < STALL_KINDS; k++) begin : g_stall
    hs_mon_stall #(.LIMIT(STALL_LIMIT)) u_stall (
      .clk  (clk),
      .rst  (rst),
      .cond (stall_cond[k]),
      .fire (stall_fire[k])
    );
  end

  // Violation detection, lowest code first.
  logic    pend_q;
  hs_err_e det;

  assign pend_q = hist_ok && prev_stb && !prev_ack;

  always_comb begin
    det = ERR_NONE;
    if (pend_q && !ch_stb) begin
      det = ERR_STB_DROP;
    end else if (hist_ok && prev_ack && !prev_stb && !ch_ack) begin
      det = ERR_ACK_DROP;
    end else if (pend_q && ch_stb && (ch_data != prev_data)) begin
      det = ERR_DATA;
    end else if (after_rst && (ch_stb || ch_ack)) begin
      det = ERR_RST;
    end else if (|stall_fire) begin
      det = ERR_STALL;
    end
  end

  hs_err_e err_q;

  always_ff @(posedge clk) begin
    if (rst || clr_err) begin
      err_q    <= ERR_NONE;
      deadlock <= 1'b0;
    end else begin
      if (err_q == ERR_NONE) begin
        err_q <= det;
      end
      if (|stall_fire) begin
        deadlock <= 1'b1;
      end
    end
  end

  assign err_code  = err_q;
  assign err_valid = (err_q != ERR_NONE);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (err_code == 3'd0 && !deadlock && xfer_count == '0));

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code != 3'd0 && !clr_err) |=> (err_code == $past(err_code)));

  // R4
  stb_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code == 3'd0 && !clr_err && !$past(rst) && $past(ch_stb) && !$past(ch_ack) && !ch_stb)
    |=> (err_code == 3'd1));

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code == 3'd0 && !clr_err && !$past(rst) && $past(ch_ack) && !$past(ch_stb) && !ch_ack)
    |=> (err_code == 3'd2));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code == 3'd0 && !clr_err && !$past(rst) && $past(ch_stb) && !$past(ch_ack) && ch_stb
     && ch_data != $past(ch_data))
    |=> (err_code == 3'd3));

  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code == 3'd0 && !clr_err && $past(rst) && (ch_stb || ch_ack)) |=> (err_code == 3'd4));

endmodule

// File: tb/hs_chan_monitor_test.sv
module hs_chan_monitor_test;

  localparam int DW  = 8;
  localparam int CW  = 4;
  localparam int LIM = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_err = 1'b0;
  logic [DW-1:0] ch_data = '0;
  logic          ch_stb = 1'b0;
  logic          ch_ack = 1'b0;
  logic          tx_pending = 1'b0;
  logic [CW-1:0] xfer_count;
  logic [DW-1:0] last_word;
  logic          err_valid;
  logic [2:0]    err_code;
  logic          deadlock;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hs_chan_monitor #(.DATA_W(DW), .CNT_W(CW), .STALL_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .ch_data(ch_data),
    .ch_stb(ch_stb), .ch_ack(ch_ack), .tx_pending(tx_pending),
    .xfer_count(xfer_count), .last_word(last_word), .err_valid(err_valid),
    .err_code(err_code), .deadlock(deadlock)
  );

  // Behavioural reference model
  int m_cnt = 0, m_word = 0, m_code = 0, m_dead = 0;
  int s_run = 0, i_run = 0;
  bit ps = 0, pa = 0, pv = 0, prst = 0;
  int pd = 0;

  always @(posedge clk) begin
    int d;
    bit fire;
    if (rst) begin
      m_cnt = 0; m_word = 0; m_code = 0; m_dead = 0;
      s_run = 0; i_run = 0; pv = 0;
    end else begin
      d = 0;
      if (pv && ps && !pa && !ch_stb) d = 1;
      else if (pv && pa && !ps && !ch_ack) d = 2;
      else if (pv && ps && !pa && ch_stb && int'(ch_data) != pd) d = 3;
      else if (prst && (ch_stb || ch_ack)) d = 4;
      s_run = (ch_stb && !ch_ack) ? s_run + 1 : 0;
      i_run = (!ch_stb && !ch_ack && tx_pending) ? i_run + 1 : 0;
      fire = (s_run == LIM) || (i_run == LIM);
      if (fire && d == 0) d = 5;
      if (ch_stb && ch_ack) begin
        if (m_cnt < CMAX) m_cnt++;
        m_word = int'(ch_data);
      end
      if (clr_err) begin
        m_code = 0; m_dead = 0;
      end else begin
        if (m_code == 0) m_code = d;
        if (fire) m_dead = 1;
      end
      pv = 1;
    end
    ps = ch_stb; pa = ch_ack; pd = int'(ch_data); prst = rst;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the rising edge.
  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 count", int'(xfer_count), m_cnt);
      chk("R2 word", int'(last_word), m_word);
      chk("R9 code", int'(err_code), m_code);
      chk("R9 valid", int'(err_valid), int'(m_code != 0));
      chk("R8 deadlock", int'(deadlock), m_dead);
    end
  end

  task automatic cyc(input bit s, input bit a, input int d, input bit p = 0,
                     input bit c = 0, input bit r = 0);
    ch_stb = s; ch_ack = a; ch_data = DW'(d); tx_pending = p; clr_err = c; rst = r;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0);
    // R1
    chk("R1 count", int'(xfer_count), 0);
    chk("R1 code", int'(err_code), 0);
    chk("R1 deadlock", int'(deadlock), 0);

    // R2 back-to-back
    cyc(1, 1, 8'hA1);
    cyc(1, 1, 8'hA2);
    chk("R2 b2b count", int'(xfer_count), 2);
    chk("R2 b2b word", int'(last_word), 8'hA2);
    cyc(0, 0, 0);

    // R6 bus changes with strobe low are ignored
    for (int i = 0; i < 4; i++) cyc(0, 0, i * 37);
    chk("R6 idle data", int'(err_code), 0);

    // Sender waits on receiver
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'h55);
    cyc(1, 1, 8'h55);
    chk("R2 after wait", int'(last_word), 8'h55);
    cyc(0, 0, 0);
    // Receiver waits on sender
    cyc(0, 1, 0); cyc(0, 1, 0);
    cyc(1, 1, 8'h66);
    chk("R2 rx wait", int'(xfer_count), 4);
    // R6 change just after a transfer is legal
    cyc(1, 1, 8'h10);
    cyc(1, 0, 8'h11);
    cyc(1, 0, 8'h11);
    cyc(1, 1, 8'h11);
    chk("R6 post xfer change", int'(err_code), 0);
    cyc(0, 0, 0);

    // R4 then R9 sticky
    cyc(1, 0, 3);
    cyc(0, 0, 3);
    chk("R4 stb drop", int'(err_code), 1);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R9 sticky", int'(err_code), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R9 clear", int'(err_code), 0);

    // R5
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R5 ack drop", int'(err_code), 2);
    cyc(0, 0, 0, 0, 1);

    // R6 unstable, then clear on a violating edge
    cyc(1, 0, 1);
    cyc(1, 0, 2);
    chk("R6 unstable", int'(err_code), 3);
    cyc(0, 0, 0, 0, 1);
    chk("R9 clear wins", int'(err_code), 0);
    cyc(0, 0, 0);

    // R8 strobe stall
    for (int i = 0; i < LIM - 1; i++) cyc(1, 0, 9);
    chk("R8 stb early", int'(deadlock), 0);
    cyc(1, 0, 9);
    chk("R8 stb dead", int'(deadlock), 1);
    chk("R8 stb code", int'(err_code), 5);
    cyc(1, 1, 9);
    cyc(0, 0, 0, 0, 1);

    // R8 both idle with word pending
    for (int i = 0; i < LIM - 1; i++) cyc(0, 0, 0, 1);
    chk("R8 idle early", int'(deadlock), 0);
    cyc(0, 0, 0, 1);
    chk("R8 idle dead", int'(err_code), 5);
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 2 * LIM; i++) cyc(0, 0, 0);
    chk("R8 no pending", int'(deadlock), 0);

    // R10 history from reset is not used
    cyc(1, 0, 4);
    cyc(1, 0, 4, 0, 0, 1);
    cyc(0, 0, 0);
    chk("R10 exempt", int'(err_code), 0);
    cyc(0, 0, 0);

    // R7
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0);
    chk("R7 rst violation", int'(err_code), 4);
    cyc(0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R1 reclear", int'(err_code), 0);
    cyc(0, 0, 0);

    // R3 saturation
    for (int i = 0; i < CMAX + 3; i++) cyc(1, 1, i);
    cyc(0, 0, 0);
    chk("R3 saturate", int'(xfer_count), CMAX);
    chk("R3 word", int'(last_word), CMAX + 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule